// File: doc/BRIEF.md
# Split F/G Stage Pair

This block is two adjacent stages of an unrolled successive-cancellation decoder pipeline. The first stage forms the right-child LLR vector from a parent vector and the left child's partial-sum bits (the G step). The second stage takes that registered vector as its parent and forms the left-child LLRs of the next tree level with the min-sum rule (the F step). Each stage holds one processing element and loads a new vector on every clock, so one parent vector can enter per cycle.

A parent vector of `2*HALF` LLRs produces `HALF` G results. Lane `i` pairs parent element `i` with element `i+HALF`. The F stage then pairs G lane `j` with lane `j+HALF/2`. Port LLRs use sign-magnitude encoding: the MSB is the sign and the low `W-1` bits are the magnitude. For long parent vectors, the G stage keeps its sum in two's complement and leaves the conversion back to sign-magnitude to the F stage. This shortens the G stage's logic path. A rate-0 flag marks a left child whose bits are all zero, and it turns G into plain addition.

Top module: `fgp_fg_pair`

## Requirements
- R1: While `rst_n` is low at a rising edge, `g_vld`, `f_vld`, `g_llr` and `f_llr` are all cleared to zero on that edge.
- R2: `g_vld` is `in_vld` delayed by one clock, and `f_vld` is `in_vld` delayed by two clocks.
- R3: G lane `i` (bits `[i*W +: W]` of `g_llr`) equals `p[i+HALF] + p[i]` when `in_psum[i]` is 0 and `p[i+HALF] - p[i]` when it is 1. Here `p[k]` is the sign-magnitude LLR at bits `[k*W +: W]` of `in_llr`, with MSB sign and low `W-1` bits magnitude.
- R4: The G result saturates to the range ±(2^(W-1)-1) and never wraps.
- R5: When `in_rate0` is 1, `in_psum` is ignored and every G lane is the plain sum `p[i+HALF] + p[i]`.
- R6: If `2*HALF > DEFER_MIN_LEN`, `g_llr` carries each saturated result as a W-bit two's-complement value. Otherwise it carries sign-magnitude, with zero encoded as positive.
- R7: F lane `j` of `f_llr` is formed from the G lanes `j` and `j+HALF/2` that were present on `g_llr` one clock earlier. Its sign is the XOR of the two signs and its magnitude is the smaller of the two magnitudes, in sign-magnitude encoding.
- R8: In two's-complement handoff mode, the F stage first converts its inputs to sign-magnitude, so `f_llr` is identical in both modes for the same stimulus.
- R9: Vectors may enter on consecutive clocks, and each result belongs to its own input vector with no interference from its neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Parent vector valid |
| in_llr | input | 2*HALF*W | Parent LLRs, sign-magnitude, element k at [k*W +: W] |
| in_psum | input | HALF | Left-child partial-sum bits, one per G lane |
| in_rate0 | input | 1 | Left child is rate-0; partial sums ignored |
| g_vld | output | 1 | G result valid |
| g_llr | output | HALF*W | Right-child LLRs, handoff encoding per R6 |
| f_vld | output | 1 | F result valid |
| f_llr | output | (HALF/2)*W | Next-level left-child LLRs, sign-magnitude |

## Verification
G results appear on `g_llr` one rising edge after the vector is driven, and F results appear on `f_llr` one edge after that. The bench drives a new vector at every falling edge and keeps expected values in a four-deep ring. At each falling edge it compares `g_llr` against the entry written one cycle earlier and `f_llr` against the entry written two cycles earlier. The reference is an unsplit integer model of G and F that is computed directly from the requirements. Two instances run side by side, one in each handoff mode, and they receive the same stimulus. A sweep covers every pair of lane-0 input codes with both partial-sum polarities, saturating sums, rate-0 vectors and periodic valid bubbles.

// File: rtl/fgp_pkg.sv
// Shared types and helpers for the split F/G stage pair.
// Assumes LLRs at block edges are sign-magnitude; the handoff between the
// two stages may be two's complement when the G vector is long.
package fgp_pkg;

    // Encoding of the vector passed from the G stage to the F stage
    typedef enum logic {
        HAND_SIGNMAG = 1'b0,
        HAND_TWOS    = 1'b1
    } handoff_e;

    // Long parent vectors defer G's final conversion into the next stage
    function automatic handoff_e pick_handoff(input int parent_len, input int min_len);
        return (parent_len > min_len) ? HAND_TWOS : HAND_SIGNMAG;
    endfunction

endpackage

// File: rtl/fgp_g_lane.sv
// One combinational G lane: combines an upper and a lower parent LLR as
// upper +/- lower, saturates to the symmetric range of W bits, and emits the
// result in the selected handoff encoding.
// Assumes: inputs are sign-magnitude; sub_i already folds in the rate-0 case.
module fgp_g_lane
    import fgp_pkg::*;
#(
    parameter int       W    = 6,
    parameter handoff_e HAND = HAND_SIGNMAG
) (
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o
);
    localparam int MAGW = W - 1;
    localparam int LMAX = (1 << (W - 1)) - 1;
    localparam logic signed [W:0] SAT_HI = (W + 1)'(LMAX);
    localparam logic signed [W:0] SAT_LO = -SAT_HI;

    logic signed [W:0] lo_mag, hi_mag;
    logic signed [W:0] lo_tc, hi_tc;
    logic signed [W:0] sum_raw, sum_sat;

    // Sign-magnitude inputs widened into two's complement
    always_comb begin
        lo_mag = {2'b00, lo_i[W-2:0]};
        hi_mag = {2'b00, hi_i[W-2:0]};
        lo_tc  = lo_i[W-1] ? -lo_mag : lo_mag;
        hi_tc  = hi_i[W-1] ? -hi_mag : hi_mag;
    end

    // Add or subtract, then clip symmetrically
    always_comb begin
        sum_raw = sub_i ? (hi_tc - lo_tc) : (hi_tc + lo_tc);
        if (sum_raw > SAT_HI)
            sum_sat = SAT_HI;
        else if (sum_raw < SAT_LO)
            sum_sat = SAT_LO;
        else
            sum_sat = sum_raw;
    end

    generate
        if (HAND == HAND_TWOS) begin : g_tc_out
            // Deferred mode: the F stage does the conversion
            assign res_o = W'(sum_sat);
        end else begin : g_sm_out
            // Direct mode: convert back to sign-magnitude here
            assign res_o = {sum_sat[W], MAGW'(sum_sat[W] ? -sum_sat : sum_sat)};
        end
    endgenerate

endmodule

// File: rtl/fgp_f_lane.sv
// One combinational F lane: min-sum of two LLRs (sign XOR, magnitude min).
// When the incoming handoff is two's complement, each input is converted to
// sign-magnitude first (the G stage's deferred step).
// Assumes: two's-complement inputs never hold the most negative code.
module fgp_f_lane
    import fgp_pkg::*;
#(
    parameter int       W    = 6,
    parameter handoff_e HAND = HAND_SIGNMAG
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    localparam int MAGW = W - 1;

    logic            a_neg, b_neg;
    logic [MAGW-1:0] a_mag, b_mag;

    assign a_neg = a_i[W-1];
    assign b_neg = b_i[W-1];

    generate
        if (HAND == HAND_TWOS) begin : g_fix
            // Deferred complement step taken over from the G stage
            assign a_mag = a_neg ? MAGW'(-a_i) : MAGW'(a_i);
            assign b_mag = b_neg ? MAGW'(-b_i) : MAGW'(b_i);
        end else begin : g_pass
            assign a_mag = a_i[W-2:0];
            assign b_mag = b_i[W-2:0];
        end
    endgenerate

    // Min-sum combine
    always_comb begin
        res_o = {a_neg ^ b_neg, (a_mag < b_mag) ? a_mag : b_mag};
    end

endmodule

// File: rtl/fgp_pipe_reg.sv
// Stage register with valid: loads every clock, cleared by synchronous
// active-low reset. Assumes the stage never stalls.
module fgp_pipe_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] data_i,
    output logic          vld_o,
    output logic [DW-1:0] data_o
);
    // Advance one stage per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            data_o <= '0;
        end else begin
            vld_o  <= vld_i;
            data_o <= data_i;
        end
    end

endmodule

// File: rtl/fgp_fg_pair.sv
// Split F/G stage pair. Stage 1 computes HALF right-child LLRs from a
// 2*HALF parent vector and partial sums; stage 2 applies min-sum to those
// registered results to give HALF/2 next-level left-child LLRs.
// For parent lengths above DEFER_MIN_LEN the G->F handoff is two's
// complement and stage 2 performs the conversion.
// Assumes: HALF is even and at least 2; W is at least 3.
module fgp_fg_pair
    import fgp_pkg::*;
#(
    parameter int W             = 6,
    parameter int HALF          = 8,
    parameter int DEFER_MIN_LEN = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [2*HALF*W-1:0]   in_llr,
    input  logic [HALF-1:0]       in_psum,
    input  logic                  in_rate0,
    output logic                  g_vld,
    output logic [HALF*W-1:0]     g_llr,
    output logic                  f_vld,
    output logic [(HALF/2)*W-1:0] f_llr
);
    localparam int       QTR  = HALF / 2;
    localparam int       PARN = 2 * HALF;
    localparam handoff_e HAND = pick_handoff(PARN, DEFER_MIN_LEN);

    logic [HALF-1:0]   sub_sel;
    logic [HALF*W-1:0] g_comb;
    logic [QTR*W-1:0]  f_comb;

    // Rate-0 left child: all partial sums are zero
    assign sub_sel = in_psum & {HALF{~in_rate0}};

    // Stage 1 datapath: one G lane per output element
    for (genvar i = 0; i < HALF; i++) begin : g_glane
        fgp_g_lane #(.W(W), .HAND(HAND)) u_g (
            .lo_i  (in_llr[i*W +: W]),
            .hi_i  (in_llr[(i+HALF)*W +: W]),
            .sub_i (sub_sel[i]),
            .res_o (g_comb[i*W +: W])
        );
    end

    fgp_pipe_reg #(.DW(HALF*W)) u_g_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_vld),
        .data_i (g_comb),
        .vld_o  (g_vld),
        .data_o (g_llr)
    );

    // Stage 2 datapath: one F lane per output element
    for (genvar j = 0; j < QTR; j++) begin : g_flane
        fgp_f_lane #(.W(W), .HAND(HAND)) u_f (
            .a_i   (g_llr[j*W +: W]),
            .b_i   (g_llr[(j+QTR)*W +: W]),
            .res_o (f_comb[j*W +: W])
        );
    end

    fgp_pipe_reg #(.DW(QTR*W)) u_f_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (g_vld),
        .data_i (f_comb),
        .vld_o  (f_vld),
        .data_o (f_llr)
    );

endmodule

// File: rtl/fgp_fg_pair_chk.sv
// Checker for fgp_fg_pair: valid timing, saturation range, and the F
// stage's sign/magnitude relation to the previous G vector.
module fgp_fg_pair_chk #(
    parameter int W             = 6,
    parameter int HALF          = 8,
    parameter int DEFER_MIN_LEN = 256
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_vld,
    input logic                  g_vld,
    input logic [HALF*W-1:0]     g_llr,
    input logic                  f_vld,
    input logic [(HALF/2)*W-1:0] f_llr
);
    localparam int QTR = HALF / 2;
    localparam bit TC  = (2 * HALF) > DEFER_MIN_LEN;
    localparam logic [W-1:0] EXTREME = {1'b1, {(W-1){1'b0}}};

    // R2
    g_vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> g_vld == $past(in_vld));

    // R2
    f_vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> f_vld == $past(g_vld));

    for (genvar i = 0; i < HALF; i++) begin : g_gl
        // R4
        g_no_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
            g_vld |-> g_llr[i*W +: W] != EXTREME);
    end

    for (genvar j = 0; j < QTR; j++) begin : g_fl
        // R7
        f_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
            f_vld |-> f_llr[j*W + W - 1] ==
                ($past(g_llr[j*W + W - 1]) ^ $past(g_llr[(j+QTR)*W + W - 1])));
        if (!TC) begin : g_sm
            // R7
            f_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
                f_vld |-> (f_llr[j*W +: W-1] <= $past(g_llr[j*W +: W-1])) &&
                          (f_llr[j*W +: W-1] <= $past(g_llr[(j+QTR)*W +: W-1])));
        end
    end

endmodule

bind fgp_fg_pair fgp_fg_pair_chk #(
    .W             (W),
    .HALF          (HALF),
    .DEFER_MIN_LEN (DEFER_MIN_LEN)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .g_vld  (g_vld),
    .g_llr  (g_llr),
    .f_vld  (f_vld),
    .f_llr  (f_llr)
);

// File: tb/fgp_fg_pair_tb.sv
// Sweep bench: two instances (deferred and direct handoff) share stimulus;
// expected values come from an integer model of unsplit G and F.
module fgp_fg_pair_tb;
    localparam int W    = 6;
    localparam int HALF = 8;
    localparam int QTR  = HALF / 2;
    localparam int LMAX = (1 << (W - 1)) - 1;
    localparam int NV   = 8192;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_vld = 1'b0;
    logic [2*HALF*W-1:0] in_llr = '0;
    logic [HALF-1:0]     in_psum = '0;
    logic                in_rate0 = 1'b0;
    logic                gv_d, fv_d, gv_s, fv_s;
    logic [HALF*W-1:0]   g_d, g_s;
    logic [QTR*W-1:0]    f_d, f_s;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    logic [W-1:0] exp_gs [4][HALF];
    logic [W-1:0] exp_gt [4][HALF];
    logic [W-1:0] exp_f  [4][QTR];
    string        exp_tag[4][HALF];
    bit           exp_v  [4];

    always #4 clk = ~clk;

    // Deferred handoff (parent length 16 > 8)
    fgp_fg_pair #(.W(W), .HALF(HALF), .DEFER_MIN_LEN(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_llr(in_llr),
        .in_psum(in_psum), .in_rate0(in_rate0),
        .g_vld(gv_d), .g_llr(g_d), .f_vld(fv_d), .f_llr(f_d));

    // Direct handoff (default threshold)
    fgp_fg_pair #(.W(W), .HALF(HALF)) u_dut_direct (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_llr(in_llr),
        .in_psum(in_psum), .in_rate0(in_rate0),
        .g_vld(gv_s), .g_llr(g_s), .f_vld(fv_s), .f_llr(f_s));

    function automatic int sm2int(input logic [W-1:0] c);
        return c[W-1] ? -int'(c[W-2:0]) : int'(c[W-2:0]);
    endfunction

    function automatic logic [W-1:0] sm_enc(input int x);
        return (x < 0) ? {1'b1, (W-1)'(-x)} : {1'b0, (W-1)'(x)};
    endfunction

    function automatic logic [W-1:0] f_ref(input int a, input int b);
        int ma = (a < 0) ? -a : a;
        int mb = (b < 0) ? -b : b;
        return {(a < 0) ^ (b < 0), (W-1)'((ma < mb) ? ma : mb)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Drive vector n and record its expected results in the ring
    task automatic drive(input int n);
        int  slot = n % 4;
        int  a = (n / 64) % 64;
        int  b = n % 64;
        bit  pass = (n >= 4096);
        bit  r0 = ((a ^ b) & 7) == 0;
        logic [HALF-1:0] ps = HALF'((3 * a + b) ^ (pass ? 255 : 0));
        int  gv[HALF];
        for (int i = 0; i < HALF; i++) begin
            logic [W-1:0] lo = W'((a + 9 * i) % 64);
            logic [W-1:0] hi = W'((b + 5 * i) % 64);
            int raw;
            in_llr[i*W +: W]        = lo;
            in_llr[(i+HALF)*W +: W] = hi;
            raw = (ps[i] && !r0) ? sm2int(hi) - sm2int(lo) : sm2int(hi) + sm2int(lo);
            gv[i] = (raw > LMAX) ? LMAX : ((raw < -LMAX) ? -LMAX : raw);
            exp_gs[slot][i] = sm_enc(gv[i]);
            exp_gt[slot][i] = W'(gv[i]);
            exp_tag[slot][i] = r0 ? "R5" : ((raw > LMAX || raw < -LMAX) ? "R4" : "R3");
        end
        for (int j = 0; j < QTR; j++)
            exp_f[slot][j] = f_ref(gv[j], gv[j+QTR]);
        in_psum  = ps;
        in_rate0 = r0;
        in_vld   = (n % 17) != 16;
        exp_v[slot] = in_vld;
    endtask

    // Compare outputs due this cycle: G from n-1, F from n-2
    task automatic check_cycle(input int n);
        int gs = (n + 3) % 4;
        int fs = (n + 2) % 4;
        chk("R2 g_vld deferred", 32'(gv_d), 32'(exp_v[gs]));
        chk("R2 g_vld direct",   32'(gv_s), 32'(exp_v[gs]));
        chk("R2 f_vld deferred", 32'(fv_d), 32'(exp_v[fs]));
        chk("R2 f_vld direct",   32'(fv_s), 32'(exp_v[fs]));
        if (exp_v[gs]) begin
            for (int i = 0; i < HALF; i++) begin
                chk({exp_tag[gs][i], " R9 G direct"}, 32'(g_s[i*W +: W]), 32'(exp_gs[gs][i]));
                chk({"R6 ", exp_tag[gs][i], " G deferred"}, 32'(g_d[i*W +: W]), 32'(exp_gt[gs][i]));
            end
        end
        if (exp_v[fs]) begin
            for (int j = 0; j < QTR; j++) begin
                chk("R7 R9 F direct",   32'(f_s[j*W +: W]), 32'(exp_f[fs][j]));
                chk("R8 F deferred",    32'(f_d[j*W +: W]), 32'(exp_f[fs][j]));
            end
        end
    endtask

    initial begin
        for (int k = 0; k < 4; k++) exp_v[k] = 1'b0;
        // R1: reset clears everything despite active inputs
        @(negedge clk);
        in_vld = 1'b1;
        in_llr = {(2*HALF*W){1'b1}};
        in_psum = '1;
        repeat (3) @(negedge clk);
        chk("R1 g_vld", 32'({gv_d, gv_s}), 32'd0);
        chk("R1 f_vld", 32'({fv_d, fv_s}), 32'd0);
        chk("R1 g_llr", 32'(|{g_d, g_s}), 32'd0);
        chk("R1 f_llr", 32'(|{f_d, f_s}), 32'd0);
        in_vld = 1'b0;
        rst_n  = 1'b1;
        // R3..R9: back-to-back sweep with periodic bubbles
        for (int n = 0; n < NV + 2; n++) begin
            @(negedge clk);
            check_cycle(n);
            if (n < NV) begin
                drive(n);
            end else begin
                in_vld = 1'b0;
                exp_v[n % 4] = 1'b0;
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule